// File: doc/BRIEF.md
# Edge Timestamp Capture Unit

This unit measures the period or duty cycle of a slow digital signal. It selects one of two already-synchronised phase inputs and watches it for transitions. On each selected transition it records the current value of a free-running timebase. The timebase counts peripheral clock cycles through a power-of-two divider. Timestamps queue in a small first-in first-out store. Software takes them out one at a time through a read port: each read removes the entry it returns.

The unit is active only while the operating-mode input selects capture. When that input is low the encoder logic that shares the pins owns them, and this unit records nothing. Two one-cycle interrupt pulses report events. One reports that an entry was written. The other reports that the fill level has reached a programmed threshold. A status output shows an empty store, and a sticky flag shows that a timestamp was lost because the store was full.

Top module: `tstamp_capture`

## Requirements
- R1: After reset, `fifo_empty` is 1 and `rd_data`, `ovf_flag`, `irq_entry` and `irq_thresh` are all 0.
- R2: Only the phase chosen by `src_b` (0 = phase A, 1 = phase B) can cause a capture. Transitions on the other phase are ignored.
- R3: With `both_edges` = 0, only low-to-high transitions are captured when `edge_rise` = 1, and only high-to-low transitions are captured when `edge_rise` = 0.
- R4: With `both_edges` = 1, every transition of the selected phase is captured, whatever `edge_rise` holds.
- R5: The stored timestamp equals floor(m / 2^`div_log2`), where m is the number of clock edges between the first edge that sees `cap_sel` high and the edge that sees the transition (that first edge counts as m = 0).
- R6: While `cap_sel` is 0 nothing is captured, no interrupt pulses, and the timebase and its divider are held at zero.
- R7: `rd_data` shows the oldest stored timestamp in the same cycle. A clock edge with `rd_pop` high removes that entry, so entries come out in capture order.
- R8: While the store is empty, `rd_data` is 0. A pop on an empty store changes nothing.
- R9: A capture that arrives while all DEPTH entries are in use is dropped and sets `ovf_flag`. The flag stays set until `cap_sel` goes low.
- R10: `irq_entry` is a one-cycle pulse in the cycle after each edge that writes an entry.
- R11: `irq_thresh` is a one-cycle pulse in the cycle after a write, taken without a pop in the same edge, raises the fill level to `thr_m1` + 1. A field value of 7 gives a threshold of 8.
- R12: `fifo_empty` is 1 exactly when no timestamp is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_sel | input | 1 | Operating mode: 1 = capture, 0 = quadrature (unit idle) |
| phase_a | input | 1 | Synchronised phase A |
| phase_b | input | 1 | Synchronised phase B |
| src_b | input | 1 | Capture source: 0 = phase A, 1 = phase B |
| both_edges | input | 1 | 1 = capture on both transitions |
| edge_rise | input | 1 | Single-edge polarity: 1 = rising, 0 = falling |
| div_log2 | input | DIV_W | log2 of the timebase divide ratio |
| thr_m1 | input | log2(DEPTH) | Threshold level minus one |
| rd_pop | input | 1 | Read strobe: removes the entry shown on rd_data |
| rd_data | output | TS_W | Oldest timestamp, 0 when empty |
| fifo_empty | output | 1 | No entries stored |
| ovf_flag | output | 1 | Sticky: a capture was dropped |
| irq_entry | output | 1 | Entry-written pulse |
| irq_thresh | output | 1 | Threshold-reached pulse |

## Verification
A transition that the bench drives after a falling clock edge is seen at the next rising edge. Its timestamp is taken from the timebase value before that edge's increment. Both interrupt pulses are registered, so the bench samples them at the falling edge one clock later, and they must be low again by the falling edge after that. `rd_data` is combinational, so the bench compares it in the same half cycle, before it raises `rd_pop`. The bench computes each expected timestamp from its own cycle count since it raised `cap_sel`, shifted right by the divider setting.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;
  localparam int unsigned TS_W_DEF  = 32;
  localparam int unsigned DEPTH_DEF = 8;
  localparam int unsigned DIV_W_DEF = 3;

  typedef enum logic {
    SRC_PHASE_A = 1'b0,
    SRC_PHASE_B = 1'b1
  } src_sel_e;
endpackage

// File: rtl/tstamp_timebase.sv
module tstamp_timebase #(
  parameter int TS_W  = 32,
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_log2,
  output logic [TS_W-1:0]  count
);
  localparam int PRE_W = (1 << DIV_W) - 1;

  logic [PRE_W-1:0] pre_q, pre_d, lim;
  logic [TS_W-1:0]  cnt_q, cnt_d;
  logic             tick;

  // terminal value of the prescaler: 2^div - 1, built bit by bit
  always_comb begin
    for (int i = 0; i < PRE_W; i++) lim[i] = (i < int'(div_log2));
  end

  assign tick = run && (pre_q == lim);

  always_comb begin
    pre_d = pre_q;
    cnt_d = cnt_q;
    if (!run) begin
      pre_d = '0;
      cnt_d = '0;
    end else if (tick) begin
      pre_d = '0;
      cnt_d = cnt_q + TS_W'(1);
    end else begin
      pre_d = pre_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

  // R5
  tb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> (count == $past(count)));
  // R5
  tb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick) |=> (count == $past(count) + TS_W'(1)));
  // R6
  tb_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (count == '0));
endmodule

// File: rtl/tstamp_edge_sel.sv
module tstamp_edge_sel
  import tstamp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic phase_a,
  input  logic phase_b,
  input  logic src_b,
  input  logic both_edges,
  input  logic edge_rise,
  output logic evt
);
  logic [1:0] now_v, prev_q;
  logic       sel_now, sel_prev, rise, fall;

  assign now_v = {phase_b, phase_a};

  // previous value of each phase is tracked all the time, so a mode or
  // source change never looks like a transition
  for (genvar g = 0; g < 2; g++) begin : g_hist
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= now_v[g];
    end
  end

  assign sel_now  = (src_sel_e'(src_b) == SRC_PHASE_B) ? now_v[1]  : now_v[0];
  assign sel_prev = (src_sel_e'(src_b) == SRC_PHASE_B) ? prev_q[1] : prev_q[0];
  assign rise     = sel_now & ~sel_prev;
  assign fall     = ~sel_now & sel_prev;
  assign evt      = both_edges ? (rise | fall) : (edge_rise ? rise : fall);
endmodule

// File: rtl/tstamp_fifo.sv
module tstamp_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic          empty,
  output logic          full,
  output logic [AW:0]   level,
  output logic          push_ok,
  output logic          pop_ok
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [AW:0]   lvl_q, lvl_d;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty   = (lvl_q == '0);
  assign full    = (lvl_q == (AW+1)'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  always_comb begin
    wr_d  = push_ok ? wrap_inc(wr_q) : wr_q;
    rd_d  = pop_ok  ? wrap_inc(rd_q) : rd_q;
    lvl_d = lvl_q;
    if (push_ok && !pop_ok) lvl_d = lvl_q + (AW+1)'(1);
    if (pop_ok && !push_ok) lvl_d = lvl_q - (AW+1)'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      lvl_q <= lvl_d;
    end
  end

  // storage: write enable only, no reset on data
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= wdata;
  end

  assign rdata = empty ? '0 : mem[rd_q];
  assign level = lvl_q;

  // R12
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= (AW+1)'(DEPTH));
  // R9
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> $stable(level));
  // R7
  pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !empty && !push) |=> (level == $past(level) - (AW+1)'(1)));
  // R8
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);
endmodule

// File: rtl/tstamp_capture.sv
module tstamp_capture
  import tstamp_pkg::*;
#(
  parameter int  TS_W  = int'(TS_W_DEF),
  parameter int  DEPTH = int'(DEPTH_DEF),
  parameter int  DIV_W = int'(DIV_W_DEF),
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_sel,
  input  logic             phase_a,
  input  logic             phase_b,
  input  logic             src_b,
  input  logic             both_edges,
  input  logic             edge_rise,
  input  logic [DIV_W-1:0] div_log2,
  input  logic [AW-1:0]    thr_m1,
  input  logic             rd_pop,
  output logic [TS_W-1:0]  rd_data,
  output logic             fifo_empty,
  output logic             ovf_flag,
  output logic             irq_entry,
  output logic             irq_thresh
);
  logic [TS_W-1:0] tb_count;
  logic            evt, cap_evt;
  logic            full, push_ok, pop_ok;
  logic [AW:0]     level, lvl_after, thr_lvl;
  logic            ovf_q, ovf_d, ient_q, ient_d, ithr_q, ithr_d;

  tstamp_timebase #(.TS_W(TS_W), .DIV_W(DIV_W)) i_timebase (
    .clk(clk), .rst_n(rst_n), .run(cap_sel), .div_log2(div_log2), .count(tb_count)
  );

  tstamp_edge_sel i_edge (
    .clk(clk), .rst_n(rst_n), .phase_a(phase_a), .phase_b(phase_b),
    .src_b(src_b), .both_edges(both_edges), .edge_rise(edge_rise), .evt(evt)
  );

  assign cap_evt = cap_sel && evt;

  tstamp_fifo #(.W(TS_W), .DEPTH(DEPTH)) i_fifo (
    .clk(clk), .rst_n(rst_n), .push(cap_evt), .wdata(tb_count), .pop(rd_pop),
    .rdata(rd_data), .empty(fifo_empty), .full(full), .level(level),
    .push_ok(push_ok), .pop_ok(pop_ok)
  );

  assign lvl_after = level + (AW+1)'(1);
  assign thr_lvl   = {1'b0, thr_m1} + (AW+1)'(1);

  always_comb begin
    ovf_d  = ovf_q;
    if (!cap_sel)              ovf_d = 1'b0;
    else if (cap_evt && full)  ovf_d = 1'b1;
    ient_d = push_ok;
    ithr_d = push_ok && !pop_ok && (lvl_after == thr_lvl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q  <= 1'b0;
      ient_q <= 1'b0;
      ithr_q <= 1'b0;
    end else begin
      ovf_q  <= ovf_d;
      ient_q <= ient_d;
      ithr_q <= ithr_d;
    end
  end

  assign ovf_flag   = ovf_q;
  assign irq_entry  = ient_q;
  assign irq_thresh = ithr_q;

  // R9
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_sel && evt && full) |=> ovf_flag);
  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && cap_sel) |=> ovf_flag);
  // R10
  entry_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_entry |-> !fifo_empty);
  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_sel |=> (!irq_entry && !irq_thresh));
  // R11
  thresh_with_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_thresh |-> irq_entry);
endmodule

// File: tb/test_tstamp_capture.sv
module test_tstamp_capture;
  localparam int TS_W = 32;
  localparam int DEPTH = 8;
  localparam int DIV_W = 3;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic cap_sel, pa, pb, src_b, both_edges, edge_rise, rd_pop;
  logic [DIV_W-1:0] div_log2;
  logic [AW-1:0] thr_m1;
  logic [TS_W-1:0] rd_data;
  logic fifo_empty, ovf_flag, irq_entry, irq_thresh;

  always #10 clk = ~clk;

  tstamp_capture #(.TS_W(TS_W), .DEPTH(DEPTH), .DIV_W(DIV_W)) i_tstamp_capture (
    .clk(clk), .rst_n(rst_n), .cap_sel(cap_sel), .phase_a(pa), .phase_b(pb),
    .src_b(src_b), .both_edges(both_edges), .edge_rise(edge_rise),
    .div_log2(div_log2), .thr_m1(thr_m1), .rd_pop(rd_pop), .rd_data(rd_data),
    .fifo_empty(fifo_empty), .ovf_flag(ovf_flag), .irq_entry(irq_entry),
    .irq_thresh(irq_thresh)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int start = 0;
  int lvl = 0;
  bit ovf_exp = 0;
  logic [TS_W-1:0] exp_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [TS_W-1:0] act, input logic [TS_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic cfg_start(input bit s, input bit b, input bit r, input int d, input int t);
    @(negedge clk);
    cap_sel = 1'b0;
    ovf_exp = 0;
    @(negedge clk);
    src_b = s; both_edges = b; edge_rise = r;
    div_log2 = DIV_W'(d); thr_m1 = AW'(t);
    cap_sel = 1'b1;
    start = cyc;
  endtask

  // drive one phase to val, then check the registered pulses one clock later
  task automatic move(input bit on_b, input bit val, input string req);
    bit cur, hit, took, thr_exp;
    logic [TS_W-1:0] ts;
    @(negedge clk);
    cur = on_b ? pb : pa;
    if (on_b) pb = val; else pa = val;
    hit = cap_sel && (on_b == src_b) && (cur != val) && (both_edges || (edge_rise == val));
    ts = TS_W'((cyc - start) >> div_log2);
    took = 0; thr_exp = 0;
    if (hit) begin
      if (lvl < DEPTH) begin
        exp_q.push_back(ts);
        lvl++;
        took = 1;
        thr_exp = (lvl == int'(thr_m1) + 1);
      end else begin
        ovf_exp = 1;
      end
    end
    @(negedge clk);
    chk({req, " R10 entry pulse"}, TS_W'(irq_entry), TS_W'(took));
    chk("R11 threshold pulse", TS_W'(irq_thresh), TS_W'(thr_exp));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain(input string req);
    while (exp_q.size() > 0) begin
      @(negedge clk);
      chk("R12 not empty", TS_W'(fifo_empty), 0);
      chk({req, " R7 head value"}, rd_data, exp_q.pop_front());
      rd_pop = 1'b1;
      @(negedge clk);
      rd_pop = 1'b0;
      lvl--;
      chk("R10 no pulse after pop", TS_W'(irq_entry), 0);
    end
    chk("R12 empty after drain", TS_W'(fifo_empty), 1);
    chk("R8 empty read value", rd_data, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; cap_sel = 0; pa = 0; pb = 0; src_b = 0; both_edges = 0;
    edge_rise = 1; rd_pop = 0; div_log2 = '0; thr_m1 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 empty", TS_W'(fifo_empty), 1);
    chk("R1 data", rd_data, 0);
    chk("R1 ovf", TS_W'(ovf_flag), 0);
    chk("R1 irq_entry", TS_W'(irq_entry), 0);
    chk("R1 irq_thresh", TS_W'(irq_thresh), 0);

    // R6 quadrature mode: no capture on any edge
    both_edges = 1;
    for (int i = 0; i < 4; i++) begin
      move(0, ~pa, "R6");
      move(1, ~pb, "R6");
    end
    chk("R6 nothing stored", TS_W'(fifo_empty), 1);

    // R5 divider sweep, irregular gaps between captures
    for (int d = 0; d < 8; d++) begin
      cfg_start(0, 1, 0, d, 7);
      for (int i = 0; i < 6; i++) begin
        idle((i * 23 + d * 7) % 41);
        move(0, ~pa, "R5");
      end
      drain("R5");
    end

    // R2, R3, R4 source and edge sweep
    for (int c = 0; c < 8; c++) begin
      cfg_start(c[0], c[1], c[2], 0, 7);
      for (int i = 0; i < 3; i++) begin
        move(0, ~pa, "R2 R3 R4");
        idle(1);
        move(1, ~pb, "R2 R3 R4");
      end
      drain("R2 R3 R4");
    end

    // R11 threshold sweep over all eight settings
    for (int t = 0; t < 8; t++) begin
      cfg_start(1, 1, 0, 0, t);
      for (int i = 0; i < 8; i++) move(1, ~pb, "R11");
      drain("R11");
    end

    // R9 overflow: ten captures into eight slots
    cfg_start(0, 1, 0, 1, 3);
    for (int i = 0; i < 10; i++) begin
      idle(i % 3);
      move(0, ~pa, "R9");
    end
    chk("R9 ovf set", TS_W'(ovf_flag), TS_W'(ovf_exp));
    drain("R9");
    chk("R9 ovf sticky", TS_W'(ovf_flag), 1);

    // R8 pop on empty leaves state alone
    @(negedge clk);
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    chk("R8 still empty", TS_W'(fifo_empty), 1);
    chk("R8 data zero", rd_data, 0);
    move(0, ~pa, "R8");
    drain("R8");

    // R9 flag clears on leaving capture mode
    @(negedge clk);
    cap_sel = 1'b0;
    @(negedge clk);
    chk("R9 ovf cleared", TS_W'(ovf_flag), 0);

    summary();
  end
endmodule